// File: doc/BRIEF.md
# Eye Monitor Sweep Accumulator

This block automates an eye-opening scan. Once a sweep is armed, it steps an external sampling comparator through a two-dimensional grid. The grid holds 64 phase positions for each of 64 amplitude-offset positions, which makes 4096 points per sweep. At every point the block counts the cycles on which the comparator reports a hit. The count runs over a dwell window set by an 8-bit accumulation setting. The finished count for each point goes out through a write port into a result buffer, so software can read results while later points are still being measured.

The dwell per point is `(acc_len + 1) << DWELL_SHIFT` sample cycles. With the default shift of 10, the largest setting gives 2^18 samples per point. A 2-bit span code picks the amplitude span of the sweep: 0 gives ±100 mV, 1 gives ±200 mV, 2 gives ±300 mV and 3 gives ±400 mV. The block captures the code at start and presents it to the comparator model for the whole sweep. A sweep runs only while the fast-mode enable is high. Dropping the enable abandons the sweep at once. The done flag marks a complete sweep, and the block refuses new starts until the enable has been lowered and raised again.

Top module: `eye_sweep_acc`

## Requirements
- R1: While reset is asserted, and after it is released, `done_o` and `wr_en_o` are 0, `phase_o`, `amp_o` and `range_o` are 0, and no sweep runs until a start is accepted.
- R2: Each grid point is sampled for exactly `(acc_len_i + 1) * 2^DWELL_SHIFT` consecutive cycles. The setting is captured when the start is accepted, and later changes to `acc_len_i` during the sweep have no effect.
- R3: The value written for a point equals the number of sample cycles in that point's window on which `hit_i` was 1. It saturates at `2^CNT_W - 1` instead of wrapping.
- R4: Phase is the inner loop and amplitude offset is the outer loop. `phase_o`/`amp_o` show the point being sampled. Exactly one write occurs per point, in the cycle after its last sample, with `wr_addr_o = {amp, phase}` (amplitude in the upper bits).
- R5: `range_o` takes the value of `range_i` when a start is accepted and holds it for the rest of the sweep, whatever `range_i` does.
- R6: A start is accepted only in the idle state, on a cycle where both `start_i` and `fast_en_i` are 1, and both may rise in the same cycle. `start_i` without `fast_en_i` is ignored, and `start_i` pulses during a running sweep are ignored.
- R7: If `fast_en_i` is 0 on any sample cycle, the sweep is abandoned. No further write occurs, the indices return to 0 on the next cycle, and `done_o` stays 0.
- R8: `done_o` rises in the same cycle as the write of the final point (address 4095). It stays 1 while `fast_en_i` remains 1, with start pulses ignored. It falls in the cycle after `fast_en_i` goes low, and a new start is then accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hit_i | input | 1 | Comparator hit strobe, sampled every cycle of a point's window |
| acc_len_i | input | ACC_W | Dwell setting per point |
| range_i | input | RANGE_W | Amplitude span code (0..3 = ±100..±400 mV) |
| fast_en_i | input | 1 | Sweep enable; low aborts or re-arms |
| start_i | input | 1 | Start request |
| phase_o | output | PHASE_BITS | Phase index being sampled |
| amp_o | output | AMP_BITS | Amplitude-offset index being sampled |
| range_o | output | RANGE_W | Span code latched for the current sweep |
| wr_en_o | output | 1 | Result write strobe |
| wr_addr_o | output | PHASE_BITS+AMP_BITS | Result address {amp, phase} |
| wr_data_o | output | CNT_W | Saturated hit count for the point |
| done_o | output | 1 | Sweep complete |

## Verification
The bench uses a 4×4 grid with a 4-bit count. That shrinks the sweep enough that every point of every sweep is checked, with its address and its count. Four hit patterns are used: none, every cycle, alternate cycles, and a count that depends on the point. No hits tells an empty window apart from stale data. Constant hits, with a window longer than the counter range, expose wrapping against saturation. Alternate hits catch a window that is off by one cycle. The point-dependent counts catch a mix-up of order or address between phase and amplitude. Separate runs try a one-cycle dwell, an abort partway through, and start pulses that should be refused: without the enable, during a sweep, and after completion.

// File: rtl/eye_sweep_pkg.sv
package eye_sweep_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } sweep_state_e;

endpackage

// File: rtl/eye_dwell_timer.sv
module eye_dwell_timer #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] lim_i,
  input  logic         run_i,
  output logic         last_o
);

  logic [W-1:0] lim_q;
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  assign last_o = (cnt_q == lim_q);

  always_comb begin
    if (!run_i) begin
      cnt_d = '0;
    end else if (last_o) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= '0;
    end else if (load_i) begin
      lim_q <= lim_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R2: the position inside a window never passes the captured limit
  p_dwell_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim_q);

  // R2: a completed window restarts from its first sample
  p_dwell_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && last_o) |=> (cnt_q == '0));

endmodule

// File: rtl/eye_hit_counter.sv
module eye_hit_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         end_i,
  input  logic         hit_i,
  output logic [W-1:0] sum_o
);

  localparam logic [W-1:0] CMAX = '1;

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  assign sum_o = (hit_i && (cnt_q != CMAX)) ? cnt_q + 1'b1 : cnt_q;

  always_comb begin
    if (!en_i || end_i) begin
      cnt_d = '0;
    end else begin
      cnt_d = sum_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R3: a full count inside a window stays full
  p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !end_i && cnt_q == CMAX) |=> (cnt_q == CMAX));

  // R3: the running count moves up by at most one per sample
  p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !end_i) |=> (cnt_q == $past(cnt_q) || cnt_q == W'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/eye_grid_stepper.sv
module eye_grid_stepper #(
  parameter int PB = 6,
  parameter int AB = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [PB-1:0] phase_o,
  output logic [AB-1:0] amp_o,
  output logic          last_o
);

  localparam logic [PB-1:0] PMAX = '1;
  localparam logic [AB-1:0] AMAX = '1;

  logic [PB-1:0] phase_q, phase_d;
  logic [AB-1:0] amp_q, amp_d;

  assign phase_o = phase_q;
  assign amp_o   = amp_q;
  assign last_o  = (phase_q == PMAX) && (amp_q == AMAX);

  always_comb begin
    phase_d = phase_q;
    amp_d   = amp_q;
    if (clr_i) begin
      phase_d = '0;
      amp_d   = '0;
    end else if (adv_i) begin
      if (phase_q == PMAX) begin
        phase_d = '0;
        amp_d   = amp_q + 1'b1;
      end else begin
        phase_d = phase_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      amp_q   <= '0;
    end else begin
      phase_q <= phase_d;
      amp_q   <= amp_d;
    end
  end

  // R4: phase steps first while amplitude waits
  p_phase_inner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && adv_i && phase_q != PMAX) |=> (phase_q == PB'($past(phase_q) + 1'b1)) && $stable(amp_q));

  // R4: amplitude moves only when phase wraps
  p_amp_outer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && adv_i && phase_q == PMAX) |=> (phase_q == '0) && (amp_q == AB'($past(amp_q) + 1'b1)));

endmodule

// File: rtl/eye_sweep_acc.sv
module eye_sweep_acc
  import eye_sweep_pkg::*;
#(
  parameter int PHASE_BITS  = 6,
  parameter int AMP_BITS    = 6,
  parameter int CNT_W       = 16,
  parameter int ACC_W       = 8,
  parameter int DWELL_SHIFT = 10,
  parameter int RANGE_W     = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         hit_i,
  input  logic [ACC_W-1:0]             acc_len_i,
  input  logic [RANGE_W-1:0]           range_i,
  input  logic                         fast_en_i,
  input  logic                         start_i,
  output logic [PHASE_BITS-1:0]        phase_o,
  output logic [AMP_BITS-1:0]          amp_o,
  output logic [RANGE_W-1:0]           range_o,
  output logic                         wr_en_o,
  output logic [PHASE_BITS+AMP_BITS-1:0] wr_addr_o,
  output logic [CNT_W-1:0]             wr_data_o,
  output logic                         done_o
);

  localparam int ADDR_W = PHASE_BITS + AMP_BITS;
  localparam int DW_W   = ACC_W + DWELL_SHIFT;
  localparam logic [DW_W-1:0] LOW_ONES = DW_W'((64'd1 << DWELL_SHIFT) - 64'd1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_ns     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_ns     <= rst_meta_q;
    end
  end

  sweep_state_e state_q, state_d;
  logic start_ok, running, dwell_last, point_end, grid_last;
  logic [DW_W-1:0] lim_w;
  logic [CNT_W-1:0] sum_w;
  logic [RANGE_W-1:0] range_q;
  logic wr_en_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [CNT_W-1:0] wr_data_q;

  assign start_ok  = (state_q == ST_IDLE) && fast_en_i && start_i;
  assign running   = (state_q == ST_RUN) && fast_en_i;
  assign point_end = running && dwell_last;
  assign lim_w     = (DW_W'(acc_len_i) << DWELL_SHIFT) | LOW_ONES;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_ok) state_d = ST_RUN;
      ST_RUN: begin
        if (!fast_en_i) state_d = ST_IDLE;
        else if (point_end && grid_last) state_d = ST_DONE;
      end
      ST_DONE: if (!fast_en_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      range_q <= '0;
    end else if (start_ok) begin
      range_q <= range_i;
    end
  end

  eye_dwell_timer #(.W(DW_W)) u_dwell (
    .clk    (clk),
    .rst_n  (rst_ns),
    .load_i (start_ok),
    .lim_i  (lim_w),
    .run_i  (running),
    .last_o (dwell_last)
  );

  eye_hit_counter #(.W(CNT_W)) u_hits (
    .clk   (clk),
    .rst_n (rst_ns),
    .en_i  (running),
    .end_i (dwell_last),
    .hit_i (hit_i),
    .sum_o (sum_w)
  );

  eye_grid_stepper #(.PB(PHASE_BITS), .AB(AMP_BITS)) u_grid (
    .clk     (clk),
    .rst_n   (rst_ns),
    .clr_i   (!running),
    .adv_i   (point_end),
    .phase_o (phase_o),
    .amp_o   (amp_o),
    .last_o  (grid_last)
  );

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      wr_en_q <= 1'b0;
    end else begin
      wr_en_q <= point_end;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else if (point_end) begin
      wr_addr_q <= {amp_o, phase_o};
      wr_data_q <= sum_w;
    end
  end

  assign range_o   = range_q;
  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
  assign done_o    = (state_q == ST_DONE);

  // R5: span code cannot move while a sweep runs
  p_range_hold_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q == ST_RUN) |=> $stable(range_o));

  // R7: abandoning a sweep leaves no trailing write
  p_abort_quiet_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q == ST_RUN && !fast_en_i) |=> (!wr_en_o && !done_o && phase_o == '0 && amp_o == '0));

  // R8: completion coincides with the final write
  p_done_with_write_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(done_o) |-> (wr_en_o && (&wr_addr_o)));

  // R8: completion holds while the enable stays high
  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    (done_o && fast_en_i) |=> (done_o && !wr_en_o));

  // R6: no write follows a cycle outside a running sweep
  p_no_write_idle_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q != ST_RUN) |=> !wr_en_o);

endmodule

// File: tb/eye_sweep_acc_tb.sv
module eye_sweep_acc_tb_top;

  localparam int PB = 2;
  localparam int AB = 2;
  localparam int CW = 4;
  localparam int NPT = (1 << PB) * (1 << AB);
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hit = 1'b0;
  logic [7:0] acc_len = '0;
  logic [1:0] range_in = '0;
  logic fast_en = 1'b0;
  logic start = 1'b0;
  logic [PB-1:0] phase;
  logic [AB-1:0] amp;
  logic [1:0] range_out;
  logic wr_en;
  logic [PB+AB-1:0] wr_addr;
  logic [CW-1:0] wr_data;
  logic done;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  eye_sweep_acc #(
    .PHASE_BITS(PB), .AMP_BITS(AB), .CNT_W(CW), .ACC_W(8), .DWELL_SHIFT(0), .RANGE_W(2)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .acc_len_i(acc_len), .range_i(range_in),
    .fast_en_i(fast_en), .start_i(start), .phase_o(phase), .amp_o(amp),
    .range_o(range_out), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit pat_hit(input int p, input int pt, input int k, input int len);
    case (p)
      0: return 1'b0;
      1: return 1'b1;
      2: return k[0];
      default: return (k < (pt % (len + 1)));
    endcase
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_checks(input string req);
    chk(wr_en == 1'b0, req, wr_en, 0);
    chk(done == 1'b0, req, done, 0);
    chk(phase == '0 && amp == '0, req, {amp, phase}, 0);
  endtask

  // one sweep; abort_at >= 0 drops the enable at that sample
  task automatic run_sweep(input int acc, input int rng, input int p, input int abort_at, input bit mid_start);
    int len = acc + 1;
    int cnt = 0;
    int prev = 0;
    fast_en  = 1'b1;
    start    = 1'b1;          // R6: enable and start in the same cycle
    acc_len  = 8'(acc);
    range_in = 2'(rng);
    hit      = 1'b0;
    step();
    start    = 1'b0;
    acc_len  = 8'(acc ^ 5);   // R2: later setting must not matter
    range_in = 2'(~rng);      // R5: later code must not matter
    for (int s = 0; s < NPT * len; s++) begin
      int pt = s / len;
      int k  = s % len;
      bit h;
      if (s == abort_at) begin
        fast_en = 1'b0;
        hit = 1'b1;
        step();
        idle_checks("R7");
        step();
        idle_checks("R7");
        return;
      end
      chk(phase == PB'(pt % (1 << PB)), "R4 phase", phase, pt % (1 << PB));
      chk(amp == AB'(pt / (1 << PB)), "R4 amp", amp, pt / (1 << PB));
      chk(range_out == 2'(rng), "R5", range_out, rng);
      chk(done == 1'b0, "R8 early", done, 0);
      if (k == 0 && s > 0) begin
        chk(wr_en == 1'b1, "R2 write timing", wr_en, 1);
        chk(wr_addr == (PB+AB)'(pt - 1), "R4 addr", wr_addr, pt - 1);
        chk(wr_data == CW'(prev), "R3 count", wr_data, prev);
      end else begin
        chk(wr_en == 1'b0, "R2 no write", wr_en, 0);
      end
      start = (mid_start && s == 5);   // R6: ignored while running
      h = pat_hit(p, pt, k, len);
      hit = h;
      if (h && cnt < CMAX) cnt++;
      if (k == len - 1) begin
        prev = cnt;
        cnt = 0;
      end
      step();
    end
    start = 1'b0;
    hit = 1'b0;
    chk(wr_en == 1'b1, "R4 final write", wr_en, 1);
    chk(wr_addr == (PB+AB)'(NPT - 1), "R4 final addr", wr_addr, NPT - 1);
    chk(wr_data == CW'(prev), "R3 final count", wr_data, prev);
    chk(done == 1'b1, "R8 done", done, 1);
    chk(phase == '0 && amp == '0, "R8 indices", {amp, phase}, 0);
    start = 1'b1;             // R8: ignored once complete
    step();
    start = 1'b0;
    for (int i = 0; i < len + 3; i++) begin
      chk(done == 1'b1, "R8 hold", done, 1);
      chk(wr_en == 1'b0, "R8 no restart", wr_en, 0);
      step();
    end
    fast_en = 1'b0;
    step();
    chk(done == 1'b0, "R8 clear", done, 0);
    step();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk(wr_en == 1'b0 && done == 1'b0, "R1 in reset", {wr_en, done}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();
    idle_checks("R1");
    chk(range_out == 2'd0, "R1 range", range_out, 0);

    // R6: start without enable, then enable without start
    start = 1'b1;
    for (int i = 0; i < 3; i++) begin step(); idle_checks("R6 no enable"); end
    start = 1'b0;
    fast_en = 1'b1;
    for (int i = 0; i < 6; i++) begin step(); idle_checks("R6 no start"); end
    fast_en = 1'b0;
    step();

    run_sweep(3, 1, 3, -1, 1'b1);   // point-dependent counts, stray start
    run_sweep(3, 2, 2, -1, 1'b0);   // alternate hits
    run_sweep(20, 3, 1, -1, 1'b0);  // R3: 21 hits saturate at 15
    run_sweep(0, 0, 1, -1, 1'b0);   // R2: single-sample dwell
    run_sweep(5, 0, 0, -1, 1'b0);   // no hits
    run_sweep(4, 1, 1, 30, 1'b0);   // R7: abort mid sweep
    run_sweep(1, 2, 3, -1, 1'b0);   // restart after abort

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule